// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-pin general-purpose I/O block on a plain 32-bit register bus. Each pin is set as an input or an output. An output pin drives its output-enable and output-value lines from a stored data word. An input pin is passed through a two-flop synchronizer and edge-detected. A detected edge on an input pin sets a sticky event bit. Software clears that bit by writing a one to it. One combined interrupt line is raised while any event bit is set and that pin's mask bit is also set.

A build parameter picks the edge-sense layout. In the single-bit style, each pin has one control bit that chooses between falling-only and any edge. In the two-bit style, each pin has a two-bit code spread over two control words. That code can also select rising-only, or nothing at all. All per-pin registers are bit-reversed: pin n lives at register bit 31−n, so pin 0 is the most significant bit. Reads and writes complete in one cycle, and read data is combinational while the select is high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero, every pad output-enable is low, and the interrupt output is low.
- R2: Byte offset 0x00 holds the direction word. A 1 at bit 31−n makes pin n an output, so `pad_oe[n]` is high and `pad_out[n]` equals bit 31−n of the data word at offset 0x08.
- R3: Reading offset 0x08 returns the stored output value for output pins, whatever their pads show. For input pins it returns the synchronized pad level.
- R4: Offsets 0x00, 0x04 (open-drain, storage only), 0x10 (mask) and 0x14 (sense control) read back the last value written. Offset 0x18 (second sense control) does the same in two-bit mode and reads zero in single-bit mode.
- R5: The event word at offset 0x0C gains a bit only for a detected edge on an input pin. The mask has no effect on this. A toggling output pin never sets its event bit.
- R6: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. If an edge and a clear hit the same bit in the same cycle, the bit stays set.
- R7: The interrupt output is high exactly when the event word ANDed with the mask word at 0x10 is nonzero.
- R8: Single-bit mode: a sense bit of 1 records falling edges only, and 0 records both rising and falling edges.
- R9: Two-bit mode: pins 0–15 take their code from offset 0x14 and pins 16–31 from offset 0x18. Pin p uses bits [2·(15−p mod 16)+1 : 2·(15−p mod 16)]. Code 00 selects any edge, 01 rising only, and 10 falling only.
- R10: Two-bit mode: code 11 records no edge in either direction.
- R11: A pad change becomes visible in a data read after two clock edges. Its event bit is set on the third clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, must be word-aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when idle |
| pad_in | input | NPINS | Pad levels, indexed by pin number |
| pad_oe | output | NPINS | Per-pin output enable |
| pad_out | output | NPINS | Per-pin output value |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two copies side by side from one shared bus and one set of pads. One copy uses the single-bit sense layout and the other uses the two-bit layout, both with 32 pins and a two-stage synchronizer. A single edge on a pad therefore exercises both sense decoders at once, and the outputs of the two copies must differ exactly where the two layouts disagree. The two-bit copy is also the only way to reach the second control word, the rising-only code and the reserved code.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
   // word index = byte offset / 4
   typedef enum logic [2:0] {
      RS_DIR  = 3'd0,
      RS_ODR  = 3'd1,
      RS_DAT  = 3'd2,
      RS_EVT  = 3'd3,
      RS_MSK  = 3'd4,
      RS_SNS  = 3'd5,
      RS_SNS2 = 3'd6
   } reg_sel_e;

   localparam logic [1:0] SNS_ANY  = 2'b00;
   localparam logic [1:0] SNS_RISE = 2'b01;
   localparam logic [1:0] SNS_FALL = 2'b10;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_sense.sv
`timescale 1ns/1ps
module gpio_edge_sense
   import gpio_edge_pkg::*;
#(
   parameter int W      = 32,
   parameter bit SENSE2 = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,    // synchronized, register bit order
   input  logic [W-1:0] sns,
   input  logic [W-1:0] sns2,
   output logic [W-1:0] hit
);
   localparam int HALF = W / 2;

   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   if (!SENSE2) begin : g_one_bit
      logic unused_sns2;
      assign unused_sns2 = ^sns2;
      assign hit = fall | (rise & ~sns);
   end else begin : g_two_bit
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic [1:0] code;
         // bit i is pin W-1-i; upper half of the register word = pins 0..HALF-1
         if (i >= HALF) begin : g_lo_pins
            assign code = sns[2*(i-HALF) +: 2];
         end else begin : g_hi_pins
            assign code = sns2[2*i +: 2];
         end
         always_comb begin
            case (code)
               SNS_ANY:  hit[i] = rise[i] | fall[i];
               SNS_RISE: hit[i] = rise[i];
               SNS_FALL: hit[i] = fall[i];
               default:  hit[i] = 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_event_reg.sv
`timescale 1ns/1ps
module gpio_event_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] ev
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev <= '0;
      else        ev <= (ev & ~clr) | set;   // new edge beats clear
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 5,
   parameter bit SENSE2      = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (NPINS != DATA_W) begin : g_chk_pins
      $error("gpio_edge_ctrl: NPINS must equal DATA_W");
   end
   if (ADDR_W < 5) begin : g_chk_addr
      $error("gpio_edge_ctrl: ADDR_W must cover offsets up to 0x18");
   end
   if (SENSE2 && (DATA_W % 2 != 0)) begin : g_chk_even
      $error("gpio_edge_ctrl: two-bit sense needs an even width");
   end

   // ---------------- bus decode ----------------
   logic [IDX_W-1:0] idx;
   logic             hit;
   reg_sel_e         sel;
   logic             wr_en;

   assign idx   = bus_addr[ADDR_W-1:2];
   assign hit   = (bus_addr[1:0] == 2'b00) && ((idx >> 3) == '0);
   assign sel   = reg_sel_e'(idx[2:0]);
   assign wr_en = bus_sel && bus_wr && hit;

   // ---------------- registers (register bit order) ----------------
   logic [DATA_W-1:0] dir_q, odr_q, dat_q, msk_q, sns_q, sns2_q;
   logic [DATA_W-1:0] ev_q, ev_clr, ev_set, edge_raw, lvl, pad_rb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         odr_q <= '0;
         dat_q <= '0;
         msk_q <= '0;
         sns_q <= '0;
      end else if (wr_en) begin
         case (sel)
            RS_DIR:  dir_q <= bus_wdata;
            RS_ODR:  odr_q <= bus_wdata;
            RS_DAT:  dat_q <= bus_wdata;
            RS_MSK:  msk_q <= bus_wdata;
            RS_SNS:  sns_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   if (SENSE2) begin : g_sns2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       sns2_q <= '0;
         else if (wr_en && sel == RS_SNS2) sns2_q <= bus_wdata;
      end
   end else begin : g_no_sns2
      assign sns2_q = '0;
   end

   // ---------------- pin mapping: pin n <-> bit NPINS-1-n ----------------
   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      assign pad_rb[NPINS-1-n] = pad_in[n];
      assign pad_oe[n]         = dir_q[NPINS-1-n];
      assign pad_out[n]        = dat_q[NPINS-1-n];
   end

   // ---------------- input path ----------------
   gpio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_rb),
      .q     (lvl)
   );

   gpio_edge_sense #(.W(DATA_W), .SENSE2(SENSE2)) u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .sns   (sns_q),
      .sns2  (sns2_q),
      .hit   (edge_raw)
   );

   assign ev_set = edge_raw & ~dir_q;
   assign ev_clr = (wr_en && sel == RS_EVT) ? bus_wdata : '0;

   gpio_event_reg #(.W(DATA_W)) u_event (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_set),
      .clr   (ev_clr),
      .ev    (ev_q)
   );

   assign irq = |(ev_q & msk_q);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && hit) begin
         case (sel)
            RS_DIR:  bus_rdata = dir_q;
            RS_ODR:  bus_rdata = odr_q;
            RS_DAT:  bus_rdata = (dat_q & dir_q) | (lvl & ~dir_q);
            RS_EVT:  bus_rdata = ev_q;
            RS_MSK:  bus_rdata = msk_q;
            RS_SNS:  bus_rdata = sns_q;
            RS_SNS2: bus_rdata = sns2_q;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_chk
   import gpio_edge_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NPINS  = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NPINS-1:0]  pad_oe,
   input logic              irq,
   input logic [DATA_W-1:0] ev_q,
   input logic [DATA_W-1:0] dir_q,
   input logic [DATA_W-1:0] edge_raw
);
   logic              wr_any, wr_evt, wr_dir, wr_msk;
   logic [NPINS-1:0]  wd_rev;
   logic [DATA_W-1:0] live_edge;

   assign wr_any    = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
   assign wr_evt    = wr_any && (bus_addr == ADDR_W'(4 * 3));
   assign wr_dir    = wr_any && (bus_addr == ADDR_W'(0));
   assign wr_msk    = wr_any && (bus_addr == ADDR_W'(4 * 4));
   assign live_edge = edge_raw & ~dir_q;

   for (genvar n = 0; n < NPINS; n++) begin : g_rev
      assign wd_rev[n] = bus_wdata[NPINS-1-n];
   end

   // R2: a direction write shows on the pad enables one cycle later
   assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (pad_oe == $past(wd_rev)));

   // R5: a new event bit never appears on a pin that was an output
   assert_no_output_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_q & ~$past(ev_q) & $past(dir_q)) == '0));

   // R6: ones written to the event word clear those bits unless an edge hit them
   assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> ((ev_q & $past(bus_wdata & ~live_edge)) == '0));

   // R6: an edge on an input pin always leaves its event bit set
   assert_edge_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_edge != '0) |=> ((ev_q & $past(live_edge)) == $past(live_edge)));

   // R7: clearing the mask silences the interrupt
   assert_mask_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_msk && bus_wdata == '0) |=> !irq);

   // R4: direction changes only through a bus write
   assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> $stable(dir_q));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
   .DATA_W (DATA_W),
   .NPINS  (NPINS),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .ev_q      (ev_q),
   .dir_q     (dir_q),
   .edge_raw  (edge_raw)
);

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] pad_in = '0;
   logic [31:0] rd1, rd2, oe1, oe2, po1, po2;
   logic        irq1, irq2;
   int n_chk = 0, n_bad = 0;
   logic [31:0] a1, a2;

   always #2.5 clk = ~clk;   // 200 MHz

   gpio_edge_ctrl #(.SENSE2(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
      .pad_in(pad_in), .pad_oe(oe1), .pad_out(po1), .irq(irq1));

   gpio_edge_ctrl #(.SENSE2(1'b1)) u_dut2 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd2),
      .pad_in(pad_in), .pad_oe(oe2), .pad_out(po2), .irq(irq2));

   // {offset, write data, expected read single-bit, expected read two-bit}
   localparam logic [100:0] TBL [6] = '{
      {5'h04, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
      {5'h10, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678},
      {5'h14, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {5'h18, 32'hCAFE_F00D, 32'h0000_0000, 32'hCAFE_F00D},
      {5'h00, 32'hC000_0001, 32'hC000_0001, 32'hC000_0001},
      {5'h08, 32'hFFFF_0000, 32'hC000_0000, 32'hC000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d1, output logic [31:0] d2);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d1 = rd1; d2 = rd2;
      bus_sel = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1: reset state
      for (int o = 0; o < 7; o++) begin
         rd(5'(o * 4), a1, a2);
         chk("R1 reg single", a1, 32'h0);
         chk("R1 reg two-bit", a2, 32'h0);
      end
      chk("R1 oe", oe1 | oe2, 32'h0);
      chk("R1 irq", {30'h0, irq1, irq2}, 32'h0);

      // R4 / R3: table walk
      for (int i = 0; i < 6; i++) begin
         wr(TBL[i][100:96], TBL[i][95:64]);
         rd(TBL[i][100:96], a1, a2);
         chk("R4 readback single", a1, TBL[i][63:32]);
         chk("R4 readback two-bit", a2, TBL[i][31:0]);
      end

      // R2: pins 0,1,31 are outputs; data drives pins 0..15 high
      chk("R2 oe", oe1, 32'h8000_0003);
      chk("R2 out", po1 & oe1, 32'h0000_0003);

      // R3 and R5: drive output pads against their values, raise input pin 5
      pad_in[0] = 1'b0; pad_in[31] = 1'b1; pad_in[5] = 1'b1;
      tick(4);
      rd(5'h08, a1, a2);
      chk("R3 data read", a1, 32'hC400_0000);
      wr(5'h14, 32'h0); wr(5'h18, 32'h0);
      // return pads, make all inputs, clear events
      pad_in = '0; tick(4);
      wr(5'h00, 32'h0); tick(4);
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h10, 32'h0);

      // R5: rising on input pin 5 with mask off; output toggles do not count
      wr(5'h00, 32'h0000_0001);          // pin 31 output
      pad_in[5] = 1'b1; pad_in[31] = 1'b1;
      tick(4);
      rd(5'h0C, a1, a2);
      chk("R5 event single", a1, 32'h0400_0000);
      chk("R5 event two-bit", a2, 32'h0400_0000);
      chk("R7 masked irq low", {31'h0, irq1}, 32'h0);

      // R7: unmask pin 5
      wr(5'h10, 32'h0400_0000);
      chk("R7 irq high", {31'h0, irq1}, 32'h1);
      // R6: zero write and write of another bit leave it
      wr(5'h0C, 32'h0);
      wr(5'h0C, 32'h0800_0000);
      rd(5'h0C, a1, a2);
      chk("R6 w1c zero keeps", a1, 32'h0400_0000);
      wr(5'h0C, 32'h0400_0000);
      rd(5'h0C, a1, a2);
      chk("R6 w1c clears", a1, 32'h0);
      chk("R7 irq drops", {31'h0, irq1}, 32'h0);
      pad_in = '0; tick(4);
      wr(5'h00, 32'h0); wr(5'h10, 32'h0);
      wr(5'h0C, 32'hFFFF_FFFF);

      // R11: synchronizer latency on pin 6 (bit 25)
      pad_in[6] = 1'b1;
      tick(1);
      rd(5'h08, a1, a2);
      chk("R11 data after one edge", a1 & 32'h0200_0000, 32'h0);
      tick(1);
      rd(5'h08, a1, a2);
      chk("R11 data after two edges", a1 & 32'h0200_0000, 32'h0200_0000);
      rd(5'h0C, a1, a2);
      chk("R11 event after two edges", a1, 32'h0);
      tick(1);
      rd(5'h0C, a1, a2);
      chk("R11 event after three edges", a1, 32'h0200_0000);
      pad_in = '0; tick(4);
      wr(5'h0C, 32'hFFFF_FFFF);

      // R8: single-bit sense, pin 5 falling only, pin 7 both
      wr(5'h14, 32'h0400_0000); wr(5'h18, 32'h0);
      pad_in[5] = 1'b1; pad_in[7] = 1'b1;
      tick(4);
      rd(5'h0C, a1, a2);
      chk("R8 rise single", a1, 32'h0100_0000);
      chk("R9 rise two-bit any", a2, 32'h0500_0000);
      wr(5'h0C, 32'hFFFF_FFFF);
      pad_in[5] = 1'b0; pad_in[7] = 1'b0;
      tick(4);
      rd(5'h0C, a1, a2);
      chk("R8 fall single", a1, 32'h0500_0000);
      chk("R9 fall two-bit any", a2, 32'h0500_0000);
      wr(5'h0C, 32'hFFFF_FFFF);

      // R9/R10: pin0 rise, pin1 fall, pin2 any, pin3 reserved, pin16 fall, pin31 rise
      wr(5'h14, 32'h6300_0000); wr(5'h18, 32'h8000_0001);
      pad_in[0] = 1'b1; pad_in[1] = 1'b1; pad_in[2] = 1'b1;
      pad_in[3] = 1'b1; pad_in[16] = 1'b1; pad_in[31] = 1'b1;
      tick(4);
      rd(5'h0C, a1, a2);
      chk("R9 rise codes two-bit", a2, 32'hA000_0001);
      chk("R10 reserved no rise", a2 & 32'h1000_0000, 32'h0);
      chk("R8 rise codes single", a1, 32'h9000_8001);
      wr(5'h0C, 32'hFFFF_FFFF);
      pad_in = '0;
      tick(4);
      rd(5'h0C, a1, a2);
      chk("R9 fall codes two-bit", a2, 32'h6000_8000);
      chk("R10 reserved no fall", a2 & 32'h1000_0000, 32'h0);
      chk("R8 fall codes single", a1, 32'hF000_8001);
      wr(5'h0C, 32'hFFFF_FFFF);

      // R6: clear and edge on pin 4 (bit 27) in the same cycle
      pad_in[4] = 1'b1; tick(4);
      pad_in[4] = 1'b0;
      tick(2);
      wr(5'h0C, 32'h0800_0000);          // edge registers on this same clock
      rd(5'h0C, a1, a2);
      chk("R6 edge beats clear single", a1, 32'h0800_0000);
      chk("R6 edge beats clear two-bit", a2, 32'h0800_0000);
      wr(5'h0C, 32'h0800_0000);
      rd(5'h0C, a1, a2);
      chk("R6 later clear", a1 | a2, 32'h0);

      summary();
      $finish;
   end
endmodule